// File: doc/BRIEF.md
# Saturating Accumulator Datapath

This block is the 32-bit accumulator path of a fixed-point signal processor. Each cycle with `op_valid` high it applies one operation to the accumulator. The source is a 16-bit data word, a 32-bit product, or the accumulator itself. The data word passes through an alignment stage first. That stage sign-extends it and shifts it left by 0 to 15 places, or it places the zero-extended word in the upper half for the high-half forms.

Signed overflow is found by comparing sign bits. Overflow sets a sticky flag. When the overflow-mode bit is set, the result is also clamped to the most positive or most negative value, chosen by the sign of the old accumulator. Only the branch-on-overflow test clears the flag.

The accumulator drives zero, negative and positive condition outputs and a 16-bit status word. It also drives a store word: the upper half of the accumulator after a left shift of 0 to 7 places. A sequencer places the status word and the store word on its data bus.

Top module: `acc_alu`

## Requirements
- R1: While reset is held and after it is released, the accumulator is 0 and the status word is 0xFEFE. That value means the overflow flag (bit 15) and the overflow-mode bit (bit 14) are both 1. Bits 13, 12:9 and 7:1 always read 1, and bits 8 and 0 always read 0.
- R2: When `op_valid` is low, the accumulator, the overflow flag and the mode bit keep their values, whatever the value of `op_code`.
- R3: For codes 1 (add), 2 (subtract) and 3 (load), the source is the 16-bit operand, sign-extended to 32 bits and shifted left by `shift_amt` (0 to 15).
- R4: For codes 4 (add high) and 5 (subtract high), the source is the zero-extended operand placed in bits 31:16, with bits 15:0 zero.
- R5: Codes 6 and 7 add the 32-bit `product` to the accumulator or subtract it from the accumulator.
- R6: An add overflows when both inputs have the same sign and the sum has the other sign. A subtract overflows when the inputs differ in sign and the difference differs in sign from the old accumulator. Overflow sets the flag. No operation other than code 16 clears the flag.
- R7: When the mode bit is 1 and an add or subtract overflows, the accumulator becomes 0x7FFFFFFF if the old accumulator was non-negative and 0x80000000 otherwise. When the mode bit is 0, the result wraps. Code 17 sets the mode bit and code 18 clears it.
- R8: Code 16 is the overflow branch test. `ov_branch` is high during that cycle exactly when the flag is set, and the flag reads 0 afterwards.
- R9: Code 8 replaces a negative accumulator with its negation. 0x80000000 becomes 0x7FFFFFFF when the mode bit is 1 and stays 0x80000000 when the mode bit is 0. Code 8 does not change the flag.
- R10: Code 9 is a division step. It forms d = acc − (zero-extended operand << 15). If d is non-negative, the new accumulator is 2·d+1; otherwise it is 2·acc. The flag is unchanged.
- R11: Code 10 ANDs with the zero-extended operand, so the upper half is cleared. Codes 11 and 12 OR and XOR the operand into bits 15:0 and keep bits 31:16.
- R12: Code 13 loads the operand into bits 15:0 and clears bits 31:16. Code 14 loads the operand into bits 31:16 and clears bits 15:0. Code 15 clears the accumulator. Code 0 does nothing.
- R13: `acc_zero`, `acc_neg` and `acc_pos` follow the signed accumulator value, and exactly one of them is high. `store_word` is bits 31:16 of the accumulator shifted left by `store_shift`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Executes `op_code` at the next clock edge |
| op_code | input | 5 | Operation select, codes 0 to 18 |
| shift_amt | input | 4 | Left shift for codes 1 to 3 |
| store_shift | input | 3 | Left shift for the store word |
| operand | input | 16 | Data operand |
| product | input | 32 | Product operand for codes 6 and 7 |
| acc_out | output | 32 | Accumulator |
| status_word | output | 16 | Flag, mode bit and fixed bits |
| acc_zero | output | 1 | Accumulator equals zero |
| acc_neg | output | 1 | Accumulator is negative |
| acc_pos | output | 1 | Accumulator is positive |
| ov_branch | output | 1 | Overflow branch is taken this cycle |
| store_word | output | 16 | Shifted upper half of the accumulator |

## Verification
The hardest cases to reach are overflow at the edges of the shifted range. Examples are a large positive accumulator meeting a source shifted by 15, and negating the most negative value, each with the mode bit in both states. The port interface has no direct load of a 32-bit value. The stimulus therefore presets each accumulator value with a high-half load followed by an OR into the low half. It then sweeps every shift amount, a set of extreme operands and both mode settings. Between the sweeps it runs branch tests so that it can observe whether the sticky flag is set or clear.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [4:0] {
    OP_NOP     = 5'd0,
    OP_ADD_SH  = 5'd1,
    OP_SUB_SH  = 5'd2,
    OP_LOAD_SH = 5'd3,
    OP_ADD_HI  = 5'd4,
    OP_SUB_HI  = 5'd5,
    OP_ADD_P   = 5'd6,
    OP_SUB_P   = 5'd7,
    OP_ABS     = 5'd8,
    OP_DIVSTEP = 5'd9,
    OP_AND     = 5'd10,
    OP_OR      = 5'd11,
    OP_XOR     = 5'd12,
    OP_ZLOAD_L = 5'd13,
    OP_ZLOAD_H = 5'd14,
    OP_ZERO    = 5'd15,
    OP_BR_OV   = 5'd16,
    OP_SET_OVM = 5'd17,
    OP_CLR_OVM = 5'd18
  } alu_op_e;

  localparam int OPC_W = 5;
endpackage

// File: rtl/acc_operand_align.sv
module acc_operand_align #(
  parameter int DATA_W = 16,
  parameter int SH_W   = 4
) (
  input  logic [DATA_W-1:0]   operand,
  input  logic [SH_W-1:0]     shift_amt,
  output logic [2*DATA_W-1:0] shifted_sx,
  output logic [2*DATA_W-1:0] high_word,
  output logic [2*DATA_W-1:0] divstep_word
);
  localparam int ACC_W = 2 * DATA_W;

  logic [ACC_W-1:0] stage [0:SH_W];

  assign stage[0] = {{DATA_W{operand[DATA_W-1]}}, operand};

  // log-depth barrel shifter, one stage per shift bit
  for (genvar g = 0; g < SH_W; g++) begin : g_stage
    assign stage[g+1] = shift_amt[g] ? (stage[g] << (1 << g)) : stage[g];
  end

  assign shifted_sx   = stage[SH_W];
  assign high_word    = {operand, {DATA_W{1'b0}}};
  assign divstep_word = {{DATA_W{1'b0}}, operand} << (DATA_W - 1);
endmodule

// File: rtl/acc_arith.sv
module acc_arith
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  alu_op_e             op,
  input  logic                op_valid,
  input  logic [2*DATA_W-1:0] acc_q,
  input  logic                ov_q,
  input  logic                ovm_q,
  input  logic [DATA_W-1:0]   operand,
  input  logic [2*DATA_W-1:0] product,
  input  logic [2*DATA_W-1:0] shifted_sx,
  input  logic [2*DATA_W-1:0] high_word,
  input  logic [2*DATA_W-1:0] divstep_word,
  output logic [2*DATA_W-1:0] acc_d,
  output logic                ov_d,
  output logic                ovm_d,
  output logic                ov_branch
);
  localparam int ACC_W = 2 * DATA_W;
  localparam int MSB   = ACC_W - 1;
  localparam logic [ACC_W-1:0] POS_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] NEG_MAX = {1'b1, {(ACC_W-1){1'b0}}};

  logic [ACC_W-1:0] src;
  logic             is_add, is_sub;
  logic [ACC_W-1:0] sum, diff, dstep, negated, clamp, zext_op;
  logic             add_ovf, sub_ovf, ovf;

  always_comb begin
    src    = product;
    is_add = 1'b0;
    is_sub = 1'b0;
    unique case (op)
      OP_ADD_SH: begin src = shifted_sx; is_add = 1'b1; end
      OP_SUB_SH: begin src = shifted_sx; is_sub = 1'b1; end
      OP_ADD_HI: begin src = high_word;  is_add = 1'b1; end
      OP_SUB_HI: begin src = high_word;  is_sub = 1'b1; end
      OP_ADD_P:  begin src = product;    is_add = 1'b1; end
      OP_SUB_P:  begin src = product;    is_sub = 1'b1; end
      default:   ;
    endcase
  end

  assign sum     = acc_q + src;
  assign diff    = acc_q - src;
  assign add_ovf = is_add && (acc_q[MSB] == src[MSB]) && (sum[MSB] != acc_q[MSB]);
  assign sub_ovf = is_sub && (acc_q[MSB] != src[MSB]) && (diff[MSB] != acc_q[MSB]);
  assign ovf     = add_ovf | sub_ovf;
  assign clamp   = acc_q[MSB] ? NEG_MAX : POS_MAX;
  assign dstep   = acc_q - divstep_word;
  assign negated = (~acc_q) + 1'b1;
  assign zext_op = {{DATA_W{1'b0}}, operand};

  always_comb begin
    acc_d     = acc_q;
    ov_d      = ov_q;
    ovm_d     = ovm_q;
    ov_branch = 1'b0;
    if (op_valid) begin
      unique case (op)
        OP_ADD_SH, OP_ADD_HI, OP_ADD_P: acc_d = (ovf && ovm_q) ? clamp : sum;
        OP_SUB_SH, OP_SUB_HI, OP_SUB_P: acc_d = (ovf && ovm_q) ? clamp : diff;
        OP_LOAD_SH: acc_d = shifted_sx;
        OP_ABS: begin
          if (acc_q[MSB]) acc_d = (acc_q == NEG_MAX && ovm_q) ? POS_MAX : negated;
        end
        OP_DIVSTEP: acc_d = dstep[MSB] ? {acc_q[MSB-1:0], 1'b0}
                                       : {dstep[MSB-1:0], 1'b1};
        OP_AND:     acc_d = acc_q & zext_op;
        OP_OR:      acc_d = acc_q | zext_op;
        OP_XOR:     acc_d = acc_q ^ zext_op;
        OP_ZLOAD_L: acc_d = zext_op;
        OP_ZLOAD_H: acc_d = high_word;
        OP_ZERO:    acc_d = '0;
        OP_BR_OV: begin
          ov_branch = ov_q;
          ov_d      = 1'b0;
        end
        OP_SET_OVM: ovm_d = 1'b1;
        OP_CLR_OVM: ovm_d = 1'b0;
        default: ;
      endcase
      if (ovf) ov_d = 1'b1;
    end
  end
endmodule

// File: rtl/acc_flags.sv
module acc_flags #(
  parameter int DATA_W = 16,
  parameter int ST_W   = 3
) (
  input  logic [2*DATA_W-1:0] acc,
  input  logic [ST_W-1:0]     store_shift,
  output logic                acc_zero,
  output logic                acc_neg,
  output logic                acc_pos,
  output logic [DATA_W-1:0]   store_word
);
  localparam int ACC_W = 2 * DATA_W;

  logic [ACC_W-1:0] st_shifted;

  assign acc_zero   = (acc == '0);
  assign acc_neg    = acc[ACC_W-1];
  assign acc_pos    = !acc[ACC_W-1] && !acc_zero;
  assign st_shifted = acc << store_shift;
  assign store_word = st_shifted[ACC_W-1:DATA_W];
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SH_W   = 4,
  parameter int ST_W   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_valid,
  input  logic [4:0]          op_code,
  input  logic [SH_W-1:0]     shift_amt,
  input  logic [ST_W-1:0]     store_shift,
  input  logic [DATA_W-1:0]   operand,
  input  logic [2*DATA_W-1:0] product,
  output logic [2*DATA_W-1:0] acc_out,
  output logic [15:0]         status_word,
  output logic                acc_zero,
  output logic                acc_neg,
  output logic                acc_pos,
  output logic                ov_branch,
  output logic [DATA_W-1:0]   store_word
);
  localparam int ACC_W = 2 * DATA_W;

  logic [1:0]       rst_pipe;
  logic             rst_n_sync;
  logic [ACC_W-1:0] acc_q, acc_d;
  logic             ov_q, ov_d, ovm_q, ovm_d;
  logic [ACC_W-1:0] shifted_sx, high_word, divstep_word;
  alu_op_e          op;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe[1];

  assign op = alu_op_e'(op_code);

  acc_operand_align #(.DATA_W(DATA_W), .SH_W(SH_W)) u_align (
    .operand      (operand),
    .shift_amt    (shift_amt),
    .shifted_sx   (shifted_sx),
    .high_word    (high_word),
    .divstep_word (divstep_word)
  );

  acc_arith #(.DATA_W(DATA_W)) u_arith (
    .op           (op),
    .op_valid     (op_valid),
    .acc_q        (acc_q),
    .ov_q         (ov_q),
    .ovm_q        (ovm_q),
    .operand      (operand),
    .product      (product),
    .shifted_sx   (shifted_sx),
    .high_word    (high_word),
    .divstep_word (divstep_word),
    .acc_d        (acc_d),
    .ov_d         (ov_d),
    .ovm_d        (ovm_d),
    .ov_branch    (ov_branch)
  );

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      acc_q <= '0;
      ov_q  <= 1'b1;
      ovm_q <= 1'b1;
    end else if (op_valid) begin
      acc_q <= acc_d;
      ov_q  <= ov_d;
      ovm_q <= ovm_d;
    end
  end

  acc_flags #(.DATA_W(DATA_W), .ST_W(ST_W)) u_flags (
    .acc         (acc_q),
    .store_shift (store_shift),
    .acc_zero    (acc_zero),
    .acc_neg     (acc_neg),
    .acc_pos     (acc_pos),
    .store_word  (store_word)
  );

  assign acc_out     = acc_q;
  assign status_word = {ov_q, ovm_q, 1'b1, 4'hF, 1'b0, 7'h7F, 1'b0};
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
  parameter int DATA_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                op_valid,
  input logic [4:0]          op_code,
  input logic [2*DATA_W-1:0] acc_out,
  input logic [15:0]         status_word,
  input logic                acc_zero,
  input logic                acc_neg,
  input logic                acc_pos,
  input logic                ov_branch
);
  logic arith_op;
  assign arith_op = op_valid && (op_code inside {5'd1, 5'd2, 5'd4, 5'd5, 5'd6, 5'd7});

  // R1
  fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[12:9] == 4'hF) && (status_word[7:1] == 7'h7F) &&
    status_word[13] && !status_word[8] && !status_word[0]);

  // R2
  hold_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(acc_out) && $stable(status_word));

  // R6
  sticky_ov_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[15] && !(op_valid && op_code == 5'd16)) |=> status_word[15]);

  // R6
  ov_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_word[15] && !arith_op) |=> !status_word[15]);

  // R8
  br_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 5'd16) |=> !status_word[15]);

  // R8
  br_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ov_branch |-> (op_valid && op_code == 5'd16 && status_word[15]));

  // R13
  flag_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({acc_zero, acc_neg, acc_pos}));
endmodule

bind acc_alu acc_alu_chk #(.DATA_W(DATA_W)) u_acc_alu_chk (
  .clk         (clk),
  .rst_n       (rst_n_sync),
  .op_valid    (op_valid),
  .op_code     (op_code),
  .acc_out     (acc_out),
  .status_word (status_word),
  .acc_zero    (acc_zero),
  .acc_neg     (acc_neg),
  .acc_pos     (acc_pos),
  .ov_branch   (ov_branch)
);

// File: tb/test_acc_alu.sv
`timescale 1ns/1ps
module test_acc_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [4:0]  op_code = '0;
  logic [3:0]  shift_amt = '0;
  logic [2:0]  store_shift = '0;
  logic [15:0] operand = '0;
  logic [31:0] product = '0;
  logic [31:0] acc_out;
  logic [15:0] status_word, store_word;
  logic        acc_zero, acc_neg, acc_pos, ov_branch;

  int checks = 0;
  int failures = 0;

  logic [31:0] m_acc;
  logic        m_ov, m_ovm;

  always #5 clk = ~clk;

  acc_alu i_acc_alu (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .shift_amt(shift_amt), .store_shift(store_shift), .operand(operand),
    .product(product), .acc_out(acc_out), .status_word(status_word),
    .acc_zero(acc_zero), .acc_neg(acc_neg), .acc_pos(acc_pos),
    .ov_branch(ov_branch), .store_word(store_word)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic string req_of(int op);
    case (op)
      1, 2, 3: return "R3";
      4, 5:    return "R4";
      6, 7:    return "R5";
      8:       return "R9";
      9:       return "R10";
      10, 11, 12: return "R11";
      13, 14, 15, 0: return "R12";
      16:      return "R8";
      default: return "R7";
    endcase
  endfunction

  // independent reference: wide signed arithmetic, range test for overflow
  task automatic model(int op, int sh, logic [15:0] opd, logic [31:0] prod);
    longint a, b, r;
    logic [31:0] d;
    logic        add_f;
    a = longint'($signed(m_acc));
    add_f = (op == 1 || op == 4 || op == 6);
    if (op >= 1 && op <= 7 && op != 3) begin
      case (op)
        1, 2: b = longint'($signed(opd)) * (longint'(1) << sh);
        4, 5: b = longint'($signed({opd, 16'h0000}));
        default: b = longint'($signed(prod));
      endcase
      r = add_f ? a + b : a - b;
      if (r > 64'sd2147483647 || r < -64'sd2147483648) begin
        m_ov = 1'b1;
        m_acc = m_ovm ? (a < 0 ? 32'h8000_0000 : 32'h7FFF_FFFF) : r[31:0];
      end else m_acc = r[31:0];
    end else begin
      case (op)
        3:  begin r = longint'($signed(opd)) * (longint'(1) << sh); m_acc = r[31:0]; end
        8:  if (a < 0) begin
              if (m_acc == 32'h8000_0000) m_acc = m_ovm ? 32'h7FFF_FFFF : 32'h8000_0000;
              else begin r = -a; m_acc = r[31:0]; end
            end
        9:  begin
              d = m_acc - (32'(opd) * 32'd32768);
              m_acc = ($signed(d) >= 0) ? d * 2 + 1 : m_acc * 2;
            end
        10: m_acc = m_acc & {16'h0, opd};
        11: m_acc = {m_acc[31:16], m_acc[15:0] | opd};
        12: m_acc = {m_acc[31:16], m_acc[15:0] ^ opd};
        13: m_acc = {16'h0, opd};
        14: m_acc = {opd, 16'h0};
        15: m_acc = 32'h0;
        16: m_ov = 1'b0;
        17: m_ovm = 1'b1;
        18: m_ovm = 1'b0;
        default: ;
      endcase
    end
  endtask

  task automatic check_outputs(string req, logic [2:0] st);
    logic [31:0] sx;
    check(req, acc_out, m_acc);
    check(req, {16'h0, status_word}, {16'h0, m_ov, m_ovm, 14'h3EFE});
    // R13
    check("R13", {29'h0, acc_zero, acc_neg, acc_pos},
          {29'h0, m_acc == 0, $signed(m_acc) < 0, $signed(m_acc) > 0});
    sx = m_acc * (32'd1 << st);
    check("R13", {16'h0, store_word}, {16'h0, sx[31:16]});
  endtask

  task automatic run(int op, int sh, logic [15:0] opd, logic [31:0] prod);
    logic [2:0] st;
    st = 3'(sh + op);
    @(negedge clk);
    op_valid = 1'b1; op_code = 5'(op); shift_amt = 4'(sh);
    operand = opd; product = prod; store_shift = st;
    #1;
    // R8: branch output in the issuing cycle
    check("R8", {31'h0, ov_branch}, {31'h0, (op == 16) && m_ov});
    @(posedge clk); #1;
    op_valid = 1'b0;
    model(op, sh, opd, prod);
    check_outputs(req_of(op), st);
  endtask

  task automatic preset(logic [31:0] v);
    run(14, 0, v[31:16], 32'h0);
    run(11, 0, v[15:0], 32'h0);
  endtask

  logic [15:0] opds [6] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h5A3C};
  logic [31:0] accs [5] = '{32'h0000_0000, 32'h7FFF_FFF0, 32'h8000_0000, 32'hFFFF_FFFF, 32'h1234_5678};
  logic [31:0] prods [4] = '{32'h7FFF_FFFF, 32'h8000_0000, 32'h0000_0001, 32'hC000_0000};

  initial begin
    #3_000_000;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    m_acc = 32'h0; m_ov = 1'b1; m_ovm = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1: values during reset
    check("R1", acc_out, 32'h0);
    check("R1", {16'h0, status_word}, 32'h0000_FEFE);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check_outputs("R1", 3'd0);

    // R2: op_valid low ignores a clear request
    preset(32'h89AB_CDEF);
    @(negedge clk); op_code = 5'd15; operand = 16'h1111;
    repeat (3) @(posedge clk);
    #1;
    check("R2", acc_out, 32'h89AB_CDEF);
    @(negedge clk); op_code = 5'd16;
    @(posedge clk); #1;
    check("R2", {31'h0, status_word[15]}, {31'h0, m_ov});

    // R6: reset leaves the flag set, the first branch test clears it
    run(16, 0, 16'h0, 32'h0);
    run(16, 0, 16'h0, 32'h0);

    for (int m = 0; m < 2; m++) begin
      run(m == 0 ? 18 : 17, 0, 16'h0, 32'h0);   // R7 mode select
      for (int op = 1; op <= 7; op++) begin
        for (int sh = 0; sh < 16; sh++) begin
          if (op > 3 && sh > 1) continue;
          for (int i = 0; i < 6; i++) begin
            for (int k = 0; k < 5; k++) begin
              preset(accs[k]);
              run(op, sh, opds[i], prods[(i + k) % 4]);
              run(16, 0, 16'h0, 32'h0);          // R6 observe and clear flag
            end
          end
        end
      end
      for (int op = 8; op <= 15; op++) begin
        for (int i = 0; i < 6; i++) begin
          for (int k = 0; k < 5; k++) begin
            preset(accs[k]);
            run(op, i, opds[i], 32'h0);
            run(op, i, opds[5 - i], 32'h0);
          end
        end
      end
    end

    // R10: repeated division steps, 0x00000064 / 7
    preset(32'h0000_0064);
    for (int s = 0; s < 16; s++) run(9, 0, 16'h0007, 32'h0);
    check("R10", {16'h0, acc_out[15:0]}, 32'd14);
    check("R10", {16'h0, acc_out[31:16]}, 32'd2);

    // R6: overflow flag is sticky across later non-overflowing arithmetic
    run(17, 0, 16'h0, 32'h0);
    preset(32'h7FFF_FFFF);
    run(1, 0, 16'h0001, 32'h0);
    run(2, 0, 16'h0001, 32'h0);
    run(0, 0, 16'h0, 32'h0);
    check("R6", {31'h0, status_word[15]}, 32'h1);
    run(16, 0, 16'h0, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule